// File: doc/BRIEF.md
# Single-Wire Debug Line Bridge

This block connects a host's full-duplex asynchronous serial link to the one-wire, open-drain, half-duplex debug pin of a target microcontroller. Each byte the host sends is queued and then serialized onto the shared wire by pulling it low. The pull-up provides the high level. Everything that crosses the wire is captured by the bridge's own line receiver and returned to the host in arrival order. This covers the bridge's own transmissions, which it hears as an echo, and the bytes the target sends back. A receive FIFO holds these bytes while the host's ready input is low.

The host can reserve a slot for a reply by sending the all-ones byte 0xFF. The bridge does not drive that byte at once. It first listens to the idle wire for a short sense window. If the target starts a frame during the window, the 0xFF is discarded and the target's byte is taken in. If the wire stays quiet, the 0xFF is driven like any other command byte. With this rule the host can keep a continuous stream going without waiting for each reply to return.

Top module: `hd_line_bridge`

## Requirements
- R1: While reset is held, and right after it is released, hostTxd is high, lineDriveLow is 0 and both sticky flags are 0.
- R2: Each byte driven on the wire is a frame of one low start bit, eight data bits least-significant first and one high stop bit, each bit lasting CLKS_PER_BIT clocks. lineDriveLow = 1 pulls the wire low, and it is 1 only inside such a frame.
- R3: Every well-framed byte seen on the wire, including the bridge's own echo, is returned to the host on hostTxd in arrival order. The host-side frame format matches R2 (high = 1).
- R4: A host byte other than 0xFF is never driven while a frame is being received from the wire. Once the preceding stop bit on the wire ends, the bridge starts driving that byte within 8 clocks.
- R5: A queued 0xFF is held for a sense window of SENSE_BITS × CLKS_PER_BIT clocks on an idle wire. If no start bit appears in that window, the 0xFF is then driven and echoed. The delay between the end of the previous driven frame and the start of the 0xFF frame is at least that window and at most the window plus 8 clocks.
- R6: If a start bit appears on the wire while a 0xFF waits in its sense window, that 0xFF is dropped and never driven. The target's byte is received and forwarded to the host.
- R7: While hostReady is 0, no new frame begins on hostTxd, and bytes from the wire stay buffered. Once hostReady returns to 1, the buffered bytes are sent in their original order.
- R8: The receive FIFO holds RX_DEPTH bytes. A wire byte arriving when it is full is dropped, and overflowFlag is set and stays set until reset. Bytes already stored are kept.
- R9: A wire byte whose stop bit is sampled low sets frameErrFlag, which stays set until reset. That byte is not forwarded to the host, and later well-framed bytes are still forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostRxd | input | 1 | Serial data from the host |
| hostTxd | output | 1 | Serial data to the host |
| hostReady | input | 1 | 1 when the host can accept bytes |
| lineIn | input | 1 | Sensed level of the shared debug wire |
| lineDriveLow | output | 1 | 1 pulls the debug wire low (open-drain enable) |
| overflowFlag | output | 1 | Sticky: a wire byte was dropped because the FIFO was full |
| frameErrFlag | output | 1 | Sticky: a wire byte had a low stop bit |

## Verification
The bench builds the bridge with CLKS_PER_BIT = 8, SENSE_BITS = 2 and RX_DEPTH = 16. Frames are therefore short enough to play back-to-back host traffic, target replies and a full FIFO overflow in a few thousand clocks. The 16-clock sense window leaves room for a target model to start replying six clocks after a driven frame ends and still land inside the window. The same window is long enough to measure its lower and upper bounds when no reply comes. The full-size FIFO is kept, so overflow occurs on the seventeenth held byte.

// File: rtl/hdlb_pkg.sv
package hdlb_pkg;

  localparam logic [7:0] PACE_BYTE = 8'hFF;

  // Requests from control to datapath, one-cycle strobes.
  typedef struct packed {
    logic lineTxGo;    // pop the host queue head and drive it on the wire
    logic headDrop;    // pop the host queue head without driving it
    logic hostSendGo;  // pop the receive FIFO head and send it to the host
  } hdlbStrobe_t;

  // Datapath state seen by control.
  typedef struct packed {
    logic       hostQEmpty;
    logic [7:0] hostQHead;
    logic       lineTxBusy;
    logic       lineRxBusy;
    logic       lineRxStart;
    logic       rxFifoEmpty;
    logic       hostTxBusy;
  } hdlbStat_t;

endpackage

// File: rtl/hdlb_uart_rx.sv
module hdlb_uart_rx #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serIn,
  output logic       busy,
  output logic       startSeen,
  output logic       byteValid,
  output logic       stopBad,
  output logic [7:0] byteData
);
  localparam int CW   = $clog2(CLKS_PER_BIT);
  localparam int HALF = CLKS_PER_BIT / 2;

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_TAIL} rxState_e;

  rxState_e        state;
  logic [1:0]      syncQ;
  logic            lineNow;
  logic [CW-1:0]   cnt;
  logic [2:0]      bitIdx;
  logic [7:0]      shiftReg;

  assign lineNow   = syncQ[1];
  assign busy      = (state != RX_IDLE);
  assign startSeen = (state == RX_IDLE) && !lineNow;
  assign byteData  = shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ     <= 2'b11;
      state     <= RX_IDLE;
      cnt       <= '0;
      bitIdx    <= '0;
      shiftReg  <= '0;
      byteValid <= 1'b0;
      stopBad   <= 1'b0;
    end else begin
      syncQ     <= {syncQ[0], serIn};
      byteValid <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (!lineNow) begin
            state <= RX_START;
            cnt   <= CW'(HALF - 1);
          end
        end
        RX_START: begin
          if (cnt == '0) begin
            if (!lineNow) begin
              state  <= RX_DATA;
              cnt    <= CW'(CLKS_PER_BIT - 1);
              bitIdx <= '0;
            end else begin
              state <= RX_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt == '0) begin
            shiftReg <= {lineNow, shiftReg[7:1]};
            cnt      <= CW'(CLKS_PER_BIT - 1);
            if (bitIdx == 3'd7) state <= RX_STOP;
            else                bitIdx <= bitIdx + 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt == '0) begin
            byteValid <= 1'b1;
            stopBad   <= !lineNow;
            state     <= RX_TAIL;
            cnt       <= CW'(HALF - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) state <= RX_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/hdlb_uart_tx.sv
module hdlb_uart_tx #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       go,
  input  logic [7:0] data,
  output logic       busy,
  output logic       serOut
);
  localparam int CW = $clog2(CLKS_PER_BIT);

  logic [9:0]    frame;
  logic [3:0]    bitsLeft;
  logic [CW-1:0] cnt;

  assign serOut = frame[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frame    <= '1;
      bitsLeft <= '0;
      cnt      <= '0;
      busy     <= 1'b0;
    end else if (!busy) begin
      if (go) begin
        frame    <= {1'b1, data, 1'b0};
        bitsLeft <= 4'd9;
        cnt      <= CW'(CLKS_PER_BIT - 1);
        busy     <= 1'b1;
      end
    end else if (cnt == '0) begin
      cnt <= CW'(CLKS_PER_BIT - 1);
      if (bitsLeft == '0) begin
        busy <= 1'b0;
      end else begin
        frame    <= {1'b1, frame[9:1]};
        bitsLeft <= bitsLeft - 1'b1;
      end
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/hdlb_fifo.sv
module hdlb_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;
  logic [NW-1:0]    count;
  logic             doPush, doPop;

  assign empty    = (count == '0);
  assign full     = (count == NW'(DEPTH));
  assign doPush   = push && !full;
  assign doPop    = pop && !empty;
  assign headData = mem[rdPtr];

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/hdlb_datapath.sv
module hdlb_datapath
  import hdlb_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int RX_DEPTH     = 16,
  parameter int HOST_Q_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostRxd,
  input  logic        lineIn,
  input  hdlbStrobe_t strobe,
  output hdlbStat_t   stat,
  output logic        hostTxd,
  output logic        lineDriveLow,
  output logic        overflowFlag,
  output logic        frameErrFlag
);
  logic       hostByteValid, hostStopBad;
  logic [7:0] hostByte;
  logic       unusedHostRxBusy, unusedHostRxStart;
  logic       hostQEmpty, hostQFull;
  logic [7:0] hostQHead;
  logic       lineTxBusy, lineTxSer;
  logic       lineRxBusy, lineRxStart, lineByteValid, lineStopBad;
  logic [7:0] lineByte;
  logic       rxFifoEmpty, rxFifoFull;
  logic [7:0] rxFifoHead;
  logic       hostTxBusy;
  logic       linePushOk;

  // Host side receiver feeding the command queue.
  hdlb_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) uHostRx (
    .clk(clk), .rstN(rstN), .serIn(hostRxd),
    .busy(unusedHostRxBusy), .startSeen(unusedHostRxStart),
    .byteValid(hostByteValid), .stopBad(hostStopBad), .byteData(hostByte)
  );

  hdlb_fifo #(.WIDTH(8), .DEPTH(HOST_Q_DEPTH)) uHostQ (
    .clk(clk), .rstN(rstN),
    .push(hostByteValid && !hostStopBad && !hostQFull), .pushData(hostByte),
    .pop(strobe.lineTxGo || strobe.headDrop),
    .headData(hostQHead), .empty(hostQEmpty), .full(hostQFull)
  );

  // Wire driver: open-drain, so a low data bit becomes a drive enable.
  hdlb_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) uLineTx (
    .clk(clk), .rstN(rstN), .go(strobe.lineTxGo), .data(hostQHead),
    .busy(lineTxBusy), .serOut(lineTxSer)
  );
  assign lineDriveLow = !lineTxSer;

  // Wire receiver hears both the echo and the target.
  hdlb_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) uLineRx (
    .clk(clk), .rstN(rstN), .serIn(lineIn),
    .busy(lineRxBusy), .startSeen(lineRxStart),
    .byteValid(lineByteValid), .stopBad(lineStopBad), .byteData(lineByte)
  );

  assign linePushOk = lineByteValid && !lineStopBad;

  hdlb_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) uRxFifo (
    .clk(clk), .rstN(rstN),
    .push(linePushOk), .pushData(lineByte),
    .pop(strobe.hostSendGo),
    .headData(rxFifoHead), .empty(rxFifoEmpty), .full(rxFifoFull)
  );

  hdlb_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) uHostTx (
    .clk(clk), .rstN(rstN), .go(strobe.hostSendGo), .data(rxFifoHead),
    .busy(hostTxBusy), .serOut(hostTxd)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overflowFlag <= 1'b0;
      frameErrFlag <= 1'b0;
    end else begin
      if (linePushOk && rxFifoFull)       overflowFlag <= 1'b1;
      if (lineByteValid && lineStopBad)   frameErrFlag <= 1'b1;
    end
  end

  always_comb begin
    stat.hostQEmpty  = hostQEmpty;
    stat.hostQHead   = hostQHead;
    stat.lineTxBusy  = lineTxBusy;
    stat.lineRxBusy  = lineRxBusy;
    stat.lineRxStart = lineRxStart;
    stat.rxFifoEmpty = rxFifoEmpty;
    stat.hostTxBusy  = hostTxBusy;
  end
endmodule

// File: rtl/hdlb_ctrl.sv
module hdlb_ctrl
  import hdlb_pkg::*;
#(
  parameter int SENSE_CYC = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostReady,
  input  hdlbStat_t   stat,
  output hdlbStrobe_t strobe
);
  localparam int SCW = $clog2(SENSE_CYC + 1);

  typedef enum logic {LN_IDLE, LN_SENSE} lnState_e;

  lnState_e       state;
  logic [SCW-1:0] senseCnt;
  logic           headReady, headIsPace;

  assign headReady  = !stat.hostQEmpty && !stat.lineTxBusy;
  assign headIsPace = (stat.hostQHead == PACE_BYTE);

  always_comb begin
    strobe            = '0;
    strobe.hostSendGo = hostReady && !stat.rxFifoEmpty && !stat.hostTxBusy;
    case (state)
      LN_IDLE: begin
        if (headReady && !headIsPace && !stat.lineRxBusy) strobe.lineTxGo = 1'b1;
      end
      default: begin
        if (stat.lineRxStart)                              strobe.headDrop = 1'b1;
        else if (senseCnt == '0 && !stat.lineRxBusy)       strobe.lineTxGo = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= LN_IDLE;
      senseCnt <= '0;
    end else begin
      case (state)
        LN_IDLE: begin
          if (headReady && headIsPace) begin
            state    <= LN_SENSE;
            senseCnt <= SCW'(SENSE_CYC - 1);
          end
        end
        default: begin
          if (strobe.headDrop || strobe.lineTxGo) state    <= LN_IDLE;
          else if (senseCnt != '0)                senseCnt <= senseCnt - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/hd_line_bridge.sv
module hd_line_bridge
  import hdlb_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int SENSE_BITS   = 2,
  parameter int RX_DEPTH     = 16,
  parameter int HOST_Q_DEPTH = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic hostRxd,
  output logic hostTxd,
  input  logic hostReady,
  input  logic lineIn,
  output logic lineDriveLow,
  output logic overflowFlag,
  output logic frameErrFlag
);
  localparam int SENSE_CYC = SENSE_BITS * CLKS_PER_BIT;

  hdlbStrobe_t ctrlStrobe;
  hdlbStat_t   dpStat;

  hdlb_ctrl #(.SENSE_CYC(SENSE_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .hostReady(hostReady),
    .stat(dpStat), .strobe(ctrlStrobe)
  );

  hdlb_datapath #(
    .CLKS_PER_BIT(CLKS_PER_BIT), .RX_DEPTH(RX_DEPTH), .HOST_Q_DEPTH(HOST_Q_DEPTH)
  ) uDp (
    .clk(clk), .rstN(rstN), .hostRxd(hostRxd), .lineIn(lineIn),
    .strobe(ctrlStrobe), .stat(dpStat),
    .hostTxd(hostTxd), .lineDriveLow(lineDriveLow),
    .overflowFlag(overflowFlag), .frameErrFlag(frameErrFlag)
  );
endmodule

// File: rtl/hdlb_checker.sv
module hdlb_checker
  import hdlb_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        hostReady,
  input logic        lineDriveLow,
  input logic        overflowFlag,
  input logic        frameErrFlag,
  input hdlbStat_t   stat,
  input hdlbStrobe_t strobe
);
  // R2: the wire is pulled low only inside a driven frame.
  a_r2_drive_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    lineDriveLow |-> stat.lineTxBusy);

  // R4: a driven frame never starts while a wire frame is being received.
  a_r4_start_on_idle_line: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stat.lineTxBusy) |-> $past(!stat.lineRxBusy));

  // R6: only a pacing byte is ever discarded.
  a_r6_drop_only_pace: assert property (@(posedge clk) disable iff (!rstN)
    strobe.headDrop |-> (stat.hostQHead == PACE_BYTE && !stat.lineTxBusy));

  // R7: a host frame begins only after hostReady was high.
  a_r7_send_needs_ready: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stat.hostTxBusy) |-> $past(hostReady));

  // R8: overflow indication is sticky.
  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);

  // R9: framing error indication is sticky.
  a_r9_framing_sticky: assert property (@(posedge clk) disable iff (!rstN)
    frameErrFlag |=> frameErrFlag);
endmodule

bind hd_line_bridge hdlb_checker chk_i (
  .clk(clk), .rstN(rstN), .hostReady(hostReady),
  .lineDriveLow(lineDriveLow), .overflowFlag(overflowFlag),
  .frameErrFlag(frameErrFlag), .stat(dpStat), .strobe(ctrlStrobe)
);

// File: tb/hd_line_bridge_tb_top.sv
module hd_line_bridge_tb_top;
  localparam int CPB   = 8;
  localparam int SBITS = 2;
  localparam int RXD   = 16;
  localparam int WIN   = SBITS * CPB;
  localparam int NVEC  = 6;
  // {stimulus byte, expected byte on the wire and back to the host}
  localparam logic [15:0] VEC [NVEC] = '{16'h0000, 16'h5A5A, 16'hA5A5,
                                          16'h0101, 16'h8080, 16'hFEFE};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, hostRxd, hostReady, targetLow, lineIn;
  wire  hostTxd, lineDriveLow, overflowFlag, frameErrFlag;
  assign lineIn = ~(lineDriveLow | targetLow);

  hd_line_bridge #(.CLKS_PER_BIT(CPB), .SENSE_BITS(SBITS), .RX_DEPTH(RXD),
                   .HOST_Q_DEPTH(4)) dut_i (
    .clk(clk), .rstN(rstN), .hostRxd(hostRxd), .hostTxd(hostTxd),
    .hostReady(hostReady), .lineIn(lineIn), .lineDriveLow(lineDriveLow),
    .overflowFlag(overflowFlag), .frameErrFlag(frameErrFlag)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0, tgtEnd = 0;
  bit finished = 1'b0;
  logic [7:0] hostB [64];
  logic [7:0] drvB  [64];
  int drvStart [64];
  int hostCnt = 0, drvCnt = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishUp();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic logic pick(input bit hostSide);
    return hostSide ? hostTxd : ~lineDriveLow;
  endfunction

  // Frame decoder on either the host output or the driven wire.
  task automatic watch(input bit hostSide);
    logic [7:0] b;
    int s;
    forever begin
      @(negedge clk);
      if (pick(hostSide) == 1'b0) begin
        s = cyc;
        repeat (CPB / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (CPB) @(negedge clk);
          b[i] = pick(hostSide);
        end
        repeat (CPB) @(negedge clk);
        if (hostSide) begin
          if (hostCnt < 64) hostB[hostCnt] = b;
          hostCnt++;
        end else begin
          if (drvCnt < 64) begin drvB[drvCnt] = b; drvStart[drvCnt] = s; end
          drvCnt++;
        end
      end
    end
  endtask

  initial watch(1'b1);
  initial watch(1'b0);

  task automatic hostSend(input logic [7:0] v);
    @(negedge clk) hostRxd = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      hostRxd = v[i];
      repeat (CPB) @(negedge clk);
    end
    hostRxd = 1'b1;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic tgtSend(input logic [7:0] v, input bit goodStop);
    @(negedge clk) targetLow = 1'b1;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      targetLow = ~v[i];
      repeat (CPB) @(negedge clk);
    end
    targetLow = ~goodStop;
    repeat (CPB) @(negedge clk);
    targetLow = 1'b0;
    tgtEnd = cyc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finishUp();
  end

  initial begin
    int h0, d0, gap;
    rstN = 1'b0; hostRxd = 1'b1; hostReady = 1'b1; targetLow = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 hostTxd idle", hostTxd, 1);
    chk("R1 line released", lineDriveLow, 0);
    chk("R1 overflow clear", overflowFlag, 0);
    chk("R1 framing clear", frameErrFlag, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 hostTxd after reset", hostTxd, 1);

    // Table walk: plain bytes are driven and echoed back (R2, R3).
    for (int v = 0; v < NVEC; v++) begin
      h0 = hostCnt; d0 = drvCnt;
      hostSend(VEC[v][15:8]);
      repeat (36 * CPB) @(negedge clk);
      chk("R2 driven count", drvCnt, d0 + 1);
      chk("R2 driven byte", drvB[d0], VEC[v][7:0]);
      chk("R3 echo count", hostCnt, h0 + 1);
      chk("R3 echo byte", hostB[h0], VEC[v][7:0]);
    end

    // R4: host byte arrives during a target frame and waits for it.
    h0 = hostCnt; d0 = drvCnt;
    fork
      hostSend(8'h3C);
      begin repeat (5 * CPB) @(negedge clk); tgtSend(8'hC3, 1'b1); end
    join
    repeat (36 * CPB) @(negedge clk);
    chk("R4 driven byte", drvB[d0], 8'h3C);
    gap = drvStart[d0] - tgtEnd;
    chk("R4 start within 8 clocks of stop end", (gap >= 0 && gap <= 8), 1);
    chk("R3 target byte first", hostB[h0], 8'hC3);
    chk("R3 echo after target", hostB[h0 + 1], 8'h3C);

    // R5: 0xFF with no reply is driven after the sense window.
    h0 = hostCnt; d0 = drvCnt;
    hostSend(8'h42);
    hostSend(8'hFF);
    repeat (40 * CPB) @(negedge clk);
    chk("R5 both driven", drvCnt, d0 + 2);
    chk("R5 pace byte driven", drvB[d0 + 1], 8'hFF);
    gap = drvStart[d0 + 1] - (drvStart[d0] + 10 * CPB);
    chk("R5 sense delay bounds", (gap >= WIN && gap <= WIN + 8), 1);
    chk("R5 pace byte echoed", hostB[h0 + 1], 8'hFF);

    // R6: target replies inside the window, so the 0xFF is dropped.
    h0 = hostCnt; d0 = drvCnt;
    fork
      begin hostSend(8'h55); hostSend(8'hFF); end
      begin
        wait (drvCnt > d0);
        repeat (CPB / 2 + 6) @(negedge clk);
        tgtSend(8'hA3, 1'b1);
      end
    join
    repeat (40 * CPB) @(negedge clk);
    chk("R6 pace byte not driven", drvCnt, d0 + 1);
    chk("R6 host count", hostCnt, h0 + 2);
    chk("R6 command echo", hostB[h0], 8'h55);
    chk("R6 target reply", hostB[h0 + 1], 8'hA3);

    // R7: hold, then release in order.
    hostReady = 1'b0;
    h0 = hostCnt;
    hostSend(8'h11);
    hostSend(8'h22);
    repeat (30 * CPB) @(negedge clk);
    chk("R7 nothing sent while held", hostCnt, h0);
    chk("R7 hostTxd idle while held", hostTxd, 1);
    hostReady = 1'b1;
    repeat (30 * CPB) @(negedge clk);
    chk("R7 count after release", hostCnt, h0 + 2);
    chk("R7 first byte", hostB[h0], 8'h11);
    chk("R7 second byte", hostB[h0 + 1], 8'h22);

    // R8: overflow with the host held.
    hostReady = 1'b0;
    h0 = hostCnt; d0 = drvCnt;
    chk("R8 flag clear before", overflowFlag, 0);
    for (int i = 0; i < RXD + 2; i++) hostSend(8'(8'h20 + i));
    repeat (20 * CPB) @(negedge clk);
    chk("R2 all bytes driven", drvCnt, d0 + RXD + 2);
    chk("R8 overflow set", overflowFlag, 1);
    hostReady = 1'b1;
    repeat (200 * CPB) @(negedge clk);
    chk("R8 stored count", hostCnt, h0 + RXD);
    for (int i = 0; i < RXD; i++) chk("R8 stored byte", hostB[h0 + i], 8'h20 + i);
    chk("R8 flag still set", overflowFlag, 1);

    // R9: bad stop bit.
    h0 = hostCnt;
    chk("R9 flag clear before", frameErrFlag, 0);
    tgtSend(8'h5A, 1'b0);
    repeat (20 * CPB) @(negedge clk);
    chk("R9 framing flag set", frameErrFlag, 1);
    chk("R9 bad byte not forwarded", hostCnt, h0);
    tgtSend(8'h96, 1'b1);
    repeat (30 * CPB) @(negedge clk);
    chk("R9 next byte forwarded", hostCnt, h0 + 1);
    chk("R9 next byte value", hostB[h0], 8'h96);
    chk("R9 flag still set", frameErrFlag, 1);

    finishUp();
  end
endmodule